// File: doc/BRIEF.md
# Multi-Word Immediate Add Sequencer

This block executes one instruction: add an immediate to one of eight 32-bit data registers. It is built around a single 16-bit adder. A start pulse carries the byte address of a 16-bit instruction word. The block reads that word from a word-wide instruction memory and takes the operand size and the destination register from it. It then fetches one or two 16-bit extension words that hold the immediate.

Each register is held as two 16-bit halves. A byte or word add takes one pass through the adder. A long add takes two passes. The low half goes first with no carry in. Its carry out is kept in a flip-flop and feeds the pass on the high half. The high extension word arrives first and is buffered until that second pass. Carry, zero, negative and overflow flags are formed at the chosen operand size when the last pass completes.

Two faults abort the instruction without touching any register or flag. An odd instruction address raises an address error. An unused size code raises an illegal-instruction signal. A combinational read port lets the surrounding logic see any register.

Top module: `imm_add_seq`

## Requirements
- R1: The instruction word is read at the start address. Its bits 7:6 give the size (00 byte, 01 word, 10 long) and its bits 2:0 select the destination register. Other bits are not decoded, so 0x0600 | (size<<6) | reg is a valid encoding.
- R2: A byte add reads one extension word at start+2 and adds its bits 7:0 into bits 7:0 of the destination. Bits 31:8 of the destination keep their old values.
- R3: A word add reads one extension word at start+2 and adds it into bits 15:0 of the destination. Bits 31:16 keep their old values.
- R4: A long add reads the upper immediate half at start+2 and the lower half at start+4. It writes the 32-bit sum modulo 2^32. The low half is added first, and its carry is passed into the high half.
- R5: After a successful add, the flags reflect the result at the operand size: C is the carry out, Z is set when the sized result is zero, N is its top bit, and V is signed overflow. The flags hold until the next successful add.
- R6: Size code 11 pulses `illegal` together with `done`. It leaves every register and every flag unchanged.
- R7: An odd start address pulses `addr_err` together with `done`. It leaves every register and every flag unchanged. No fetch is ever issued at an odd address.
- R8: Timing is counted from the clock edge that samples `start` in idle. `done` pulses for one cycle after 3 further edges for a byte or word add, after 5 for a long add, and after 1 for a fault. `busy` is high from that edge until `done`, and `start` is ignored while busy.
- R9: `rd_val` shows register `rd_idx` combinationally. All registers and all flags are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction, sampled while idle |
| pc | input | 16 | Byte address of the instruction word |
| mem_rd | output | 1 | Instruction memory read strobe |
| mem_addr | output | 16 | Byte address of the word being read |
| mem_rdata | input | 16 | Word returned by memory in the same cycle |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Size code 11 seen, valid with done |
| addr_err | output | 1 | Odd start address, valid with done |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| rd_idx | input | 3 | Register select for the read port |
| rd_val | output | 32 | Contents of the selected register |

## Verification
The hardest case to reach is a long add whose low pass produces a carry that must ripple through the buffered high pass. Two variants matter most: the case where that carry alone sets overflow, and the case where the 32-bit result is zero only because both halves cancel. The stimulus builds these deliberately. For each register and size it issues an immediate equal to the two's complement of the register's current sized value, which forces a zero result with carry out. It also adds all-ones and signed-boundary immediates to registers preloaded with pseudo-random long values. Every sized result, the untouched upper bits of all eight registers and the four flags are then compared with arithmetic done in the bench.

// File: rtl/imm_add_pkg.sv
package imm_add_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_OP,
        S_EXT1,
        S_EXT2,
        S_LO,
        S_HI
    } seq_state_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_WORD = 2'b01;
    localparam logic [1:0] SZ_LONG = 2'b10;
    localparam logic [1:0] SZ_BAD  = 2'b11;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
        logic v;
    } flags_t;
endpackage

// File: rtl/imm_add_alu.sv
module imm_add_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[W];
    end
endmodule

// File: rtl/imm_add_regfile.sv
module imm_add_regfile #(
    parameter int W     = 16,
    parameter int NREGS = 8,
    localparam int REG_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_lo,
    input  logic             we_hi,
    input  logic [REG_W-1:0] widx,
    input  logic [W-1:0]     wdata,
    input  logic [REG_W-1:0] a_idx,
    output logic [W-1:0]     a_lo,
    output logic [W-1:0]     a_hi,
    input  logic [REG_W-1:0] b_idx,
    output logic [2*W-1:0]   b_val
);
    logic [W-1:0] lo_q [NREGS];
    logic [W-1:0] hi_q [NREGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                lo_q[i] <= '0;
                hi_q[i] <= '0;
            end
        end else begin
            if (we_lo) lo_q[widx] <= wdata;
            if (we_hi) hi_q[widx] <= wdata;
        end
    end

    always_comb begin
        a_lo  = lo_q[a_idx];
        a_hi  = hi_q[a_idx];
        b_val = {hi_q[b_idx], lo_q[b_idx]};
    end

    // R4: a long add writes the low half one cycle before the high half
    assert_hi_after_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we_hi |-> $past(we_lo));
endmodule

// File: rtl/imm_add_seq.sv
module imm_add_seq
    import imm_add_pkg::*;
#(
    parameter int W      = 16,
    parameter int NREGS  = 8,
    parameter int ADDR_W = 16,
    localparam int REG_W = $clog2(NREGS),
    localparam int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] pc,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [W-1:0]      mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              illegal,
    output logic              addr_err,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_v,
    input  logic [REG_W-1:0]  rd_idx,
    output logic [2*W-1:0]    rd_val
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(W / 8);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size;
        logic [REG_W-1:0]  idx;
        logic [W-1:0]      op_lo;
        logic [W-1:0]      op_hi;
        logic              carry;
        logic              zlo;
        flags_t            flg;
        logic              done;
        logic              illegal;
        logic              aerr;
    } seq_t;

    seq_t q, d;

    logic [W-1:0] alu_a, alu_b, alu_sum, wdata, rf_lo, rf_hi;
    logic         alu_cin, alu_cout, we_lo, we_hi;

    imm_add_alu #(.W(W)) u_alu (
        .a(alu_a), .b(alu_b), .cin(alu_cin), .sum(alu_sum), .cout(alu_cout)
    );

    imm_add_regfile #(.W(W), .NREGS(NREGS)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we_lo(we_lo), .we_hi(we_hi), .widx(q.idx), .wdata(wdata),
        .a_idx(q.idx), .a_lo(rf_lo), .a_hi(rf_hi),
        .b_idx(rd_idx), .b_val(rd_val)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.illegal = 1'b0;
        d.aerr    = 1'b0;
        mem_rd    = 1'b0;
        mem_addr  = q.addr;
        we_lo     = 1'b0;
        we_hi     = 1'b0;
        alu_a     = rf_lo;
        alu_b     = q.op_lo;
        alu_cin   = 1'b0;
        wdata     = alu_sum;

        if (q.st == S_HI) begin
            alu_a   = rf_hi;
            alu_b   = q.op_hi;
            alu_cin = q.carry;
        end else if (q.size == SZ_BYTE) begin
            alu_a = {{(W-BYTE_W){1'b0}}, rf_lo[BYTE_W-1:0]};
            wdata = {rf_lo[W-1:BYTE_W], alu_sum[BYTE_W-1:0]};
        end

        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.addr = pc;
                    d.st   = S_OP;
                end
            end
            S_OP: begin
                if (q.addr[0]) begin
                    d.aerr = 1'b1;
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end else begin
                    mem_rd = 1'b1;
                    d.size = mem_rdata[7:6];
                    d.idx  = mem_rdata[REG_W-1:0];
                    if (mem_rdata[7:6] == SZ_BAD) begin
                        d.illegal = 1'b1;
                        d.done    = 1'b1;
                        d.st      = S_IDLE;
                    end else begin
                        d.addr = q.addr + STEP;
                        d.st   = S_EXT1;
                    end
                end
            end
            S_EXT1: begin
                mem_rd = 1'b1;
                if (q.size == SZ_LONG) begin
                    d.op_hi = mem_rdata;
                    d.addr  = q.addr + STEP;
                    d.st    = S_EXT2;
                end else begin
                    d.op_lo = (q.size == SZ_BYTE)
                            ? {{(W-BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]}
                            : mem_rdata;
                    d.st    = S_LO;
                end
            end
            S_EXT2: begin
                mem_rd  = 1'b1;
                d.op_lo = mem_rdata;
                d.st    = S_LO;
            end
            S_LO: begin
                we_lo = 1'b1;
                if (q.size == SZ_LONG) begin
                    d.carry = alu_cout;
                    d.zlo   = (alu_sum == '0);
                    d.st    = S_HI;
                end else begin
                    if (q.size == SZ_BYTE) begin
                        d.flg.c = alu_sum[BYTE_W];
                        d.flg.n = alu_sum[BYTE_W-1];
                        d.flg.z = (alu_sum[BYTE_W-1:0] == '0);
                        d.flg.v = (alu_a[BYTE_W-1] == alu_b[BYTE_W-1]) &&
                                  (alu_sum[BYTE_W-1] != alu_a[BYTE_W-1]);
                    end else begin
                        d.flg.c = alu_cout;
                        d.flg.n = alu_sum[W-1];
                        d.flg.z = (alu_sum == '0);
                        d.flg.v = (alu_a[W-1] == alu_b[W-1]) &&
                                  (alu_sum[W-1] != alu_a[W-1]);
                    end
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            S_HI: begin
                we_hi   = 1'b1;
                d.flg.c = alu_cout;
                d.flg.n = alu_sum[W-1];
                d.flg.z = q.zlo && (alu_sum == '0);
                d.flg.v = (alu_a[W-1] == alu_b[W-1]) &&
                          (alu_sum[W-1] != alu_a[W-1]);
                d.done  = 1'b1;
                d.st    = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        busy     = (q.st != S_IDLE);
        done     = q.done;
        illegal  = q.illegal;
        addr_err = q.aerr;
        flag_c   = q.flg.c;
        flag_z   = q.flg.z;
        flag_n   = q.flg.n;
        flag_v   = q.flg.v;
    end

    // R8: completion is reported only once the sequence is back in idle
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: a successful completion follows a register write
    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !illegal && !addr_err) |-> $past(we_lo || we_hi));

    // R6: a rejected size code never writes a register
    assert_illegal_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !$past(we_lo || we_hi));

    // R7: memory is never read at an odd byte address
    assert_even_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !mem_addr[0]);

    // R7: an address fault never writes a register
    assert_aerr_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> !$past(we_lo || we_hi));
endmodule

// File: tb/imm_add_seq_tb.sv
module imm_add_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] pc = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        busy, done, illegal, addr_err;
    logic        flag_c, flag_z, flag_n, flag_v;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_val;

    logic [15:0] mem [64];
    logic [31:0] mreg [8];
    logic [3:0]  mflg;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] lfsr = 32'h1D2C_3B4A;

    always #10 clk = ~clk;

    assign mem_rdata = mem[mem_addr[6:1]];

    imm_add_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pc(pc),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .illegal(illegal), .addr_err(addr_err),
        .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v),
        .rd_idx(rd_idx), .rd_val(rd_val)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    task automatic check_regs(input string tag);
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #1;
            chk(rd_val == mreg[i], tag, rd_val, mreg[i]);
        end
    endtask

    task automatic run(input logic [15:0] addr, input logic [15:0] op,
                       input logic [15:0] e1, input logic [15:0] e2,
                       output int lat, output logic ill, output logic ae);
        mem[addr[6:1]] = op;
        mem[(addr[6:1] + 6'd1)] = e1;
        mem[(addr[6:1] + 6'd2)] = e2;
        @(negedge clk);
        pc = addr;
        start = 1'b1;
        lat = 0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        chk(busy, "R8 busy after start", 32'(busy), 32'd1);
        while (!done) begin
            @(negedge clk);
            lat++;
        end
        ill = illegal;
        ae = addr_err;
    endtask

    task automatic model(input int sz, input int r, input logic [31:0] imm);
        logic [32:0] s;
        logic [31:0] a;
        a = mreg[r];
        if (sz == 0) begin
            s = {25'd0, a[7:0]} + {25'd0, imm[7:0]};
            mflg = {s[8], s[7:0] == 8'd0, s[7],
                    (a[7] == imm[7]) && (s[7] != a[7])};
            mreg[r] = {a[31:8], s[7:0]};
        end else if (sz == 1) begin
            s = {17'd0, a[15:0]} + {17'd0, imm[15:0]};
            mflg = {s[16], s[15:0] == 16'd0, s[15],
                    (a[15] == imm[15]) && (s[15] != a[15])};
            mreg[r] = {a[31:16], s[15:0]};
        end else begin
            s = {1'b0, a} + {1'b0, imm};
            mflg = {s[32], s[31:0] == 32'd0, s[31],
                    (a[31] == imm[31]) && (s[31] != a[31])};
            mreg[r] = s[31:0];
        end
    endtask

    task automatic do_add(input int sz, input int r, input logic [31:0] imm,
                          input logic [15:0] addr);
        int lat;
        logic ill, ae;
        logic [15:0] op;
        logic [3:0] fl;
        op = 16'h0600 | 16'(sz << 6) | 16'(r);
        if (sz == 2) run(addr, op, imm[31:16], imm[15:0], lat, ill, ae);
        else if (sz == 1) run(addr, op, imm[15:0], 16'hDEAD, lat, ill, ae);
        else run(addr, op, {8'h00, imm[7:0]}, 16'hDEAD, lat, ill, ae);
        model(sz, r, imm);
        chk(lat == ((sz == 2) ? 6 : 4), "R8 latency", 32'(lat),
            (sz == 2) ? 32'd6 : 32'd4);
        chk(!ill && !ae, "R1 no fault", {30'd0, ill, ae}, 32'd0);
        fl = {flag_c, flag_z, flag_n, flag_v};
        chk(fl == mflg, "R5 flags", 32'(fl), 32'(mflg));
        rd_idx = 3'(r);
        #1;
        if (sz == 0) chk(rd_val == mreg[r], "R2 byte result", rd_val, mreg[r]);
        else if (sz == 1) chk(rd_val == mreg[r], "R3 word result", rd_val, mreg[r]);
        else chk(rd_val == mreg[r], "R4 long result", rd_val, mreg[r]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int lat;
        logic ill, ae;
        logic [31:0] imm;
        logic [3:0] fl;
        int run_n;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        for (int i = 0; i < 8; i++) mreg[i] = '0;
        mflg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(!busy && !done, "R9 reset idle", {30'd0, busy, done}, 32'd0);
        chk({flag_c, flag_z, flag_n, flag_v} == 4'd0, "R9 reset flags",
            32'({flag_c, flag_z, flag_n, flag_v}), 32'd0);
        check_regs("R9 reset registers");

        // R4: preload every register through long adds into zero
        for (int r = 0; r < 8; r++) do_add(2, r, nxt(), 16'(r * 8));
        check_regs("R4 preload");

        run_n = 0;
        for (int sz = 0; sz < 3; sz++) begin
            for (int r = 0; r < 8; r++) begin
                for (int k = 0; k < 7; k++) begin
                    case (k)
                        0: imm = 32'd0 - mreg[r];
                        1: imm = 32'hFFFF_FFFF;
                        2: imm = (sz == 0) ? 32'h7F : (sz == 1) ? 32'h7FFF : 32'h7FFF_FFFF;
                        3: imm = (sz == 0) ? 32'h80 : (sz == 1) ? 32'h8000 : 32'h8000_0000;
                        4: imm = 32'd1;
                        5: imm = 32'h0000_FFFF;
                        default: imm = nxt();
                    endcase
                    if (sz == 0) imm = {24'd0, imm[7:0]};
                    else if (sz == 1) imm = {16'd0, imm[15:0]};
                    do_add(sz, r, imm, 16'((run_n % 8) * 8 + 64));
                    run_n++;
                end
                if (sz == 0) check_regs("R2 upper bits kept");
                else if (sz == 1) check_regs("R3 upper bits kept");
                else check_regs("R4 other registers kept");
            end
        end

        // R6: size code 11 is rejected
        for (int r = 0; r < 8; r++) begin
            fl = {flag_c, flag_z, flag_n, flag_v};
            run(16'(r * 4), 16'h06C0 | 16'(r), 16'h1234, 16'h5678, lat, ill, ae);
            chk(ill && !ae, "R6 illegal pulse", {30'd0, ill, ae}, 32'd2);
            chk(lat == 2, "R6 fault latency", 32'(lat), 32'd2);
            @(negedge clk);
            chk({flag_c, flag_z, flag_n, flag_v} == fl, "R6 flags kept",
                32'({flag_c, flag_z, flag_n, flag_v}), 32'(fl));
            check_regs("R6 registers kept");
        end

        // R7: odd start address aborts
        for (int r = 0; r < 4; r++) begin
            fl = {flag_c, flag_z, flag_n, flag_v};
            mem[(r * 2 + 10)] = 16'h0680 | 16'(r);
            run(16'(r * 4 + 21), 16'h0640, 16'hFFFF, 16'hFFFF, lat, ill, ae);
            chk(ae && !ill, "R7 address error pulse", {30'd0, ill, ae}, 32'd1);
            chk(lat == 2, "R7 fault latency", 32'(lat), 32'd2);
            chk({flag_c, flag_z, flag_n, flag_v} == fl, "R7 flags kept",
                32'({flag_c, flag_z, flag_n, flag_v}), 32'(fl));
            check_regs("R7 registers kept");
        end

        // R8: start while busy is ignored; R1: undecoded bits ignored
        mem[0] = 16'hF93D; // size 00, reg 5, other bits set
        mem[1] = 16'h00A5;
        mem[2] = 16'h0642; // would be a word add to reg 2 if restarted there
        @(negedge clk);
        pc = 16'd0;
        start = 1'b1;
        @(negedge clk);
        pc = 16'd4;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        model(0, 5, 32'h0000_00A5);
        @(negedge clk);
        chk(!busy, "R8 no restart while busy", 32'(busy), 32'd0);
        check_regs("R1 undecoded bits ignored");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule